// File: doc/BRIEF.md
# Indirect Clock-Synthesizer Register Port

This block holds the small set of 8-bit control registers that steer a clock synthesizer: a reference divider, general and extended control bytes, a packed post-divider selector register and one feedback divider per pixel clock. A host cannot reach these registers directly. It first writes an address byte that carries a register offset and a write-enable flag, and then moves one byte through a data port. A write goes through only while the latched write-enable flag is set. A read returns the register picked by the latched offset.

A separate clock-select input picks which of the pixel clocks is active. The block then brings out the post-divider field and the feedback divider of that clock on their own outputs, so that a downstream divider model can use them. It also brings out the full register contents and the memory-clock post-divider code taken from the extended control byte. The block produces no clocks, models no analog loop and does no lock detection.

Top module: `pllreg_port`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, every register, the latched offset, the write-enable flag and `clk_sel` clear to zero, so every read and every output reads 0.
- R2: On a clock edge with `addr_wr` high, the block latches `addr_in[7:2]` as the register offset and `addr_in[1]` as the write-enable flag. `addr_in[0]` is ignored.
- R3: On a clock edge with `data_wr` high and the latched write-enable flag set, `data_in` is stored into the register at the latched offset. The offsets are: general control 0x01, reference divider 0x03, post-divider selectors 0x04, feedback dividers 0x08 to 0x0B, extended control 0x0C.
- R4: A `data_wr` while the latched write-enable flag is clear changes no register.
- R5: `data_out` shows the register at the latched offset at all times. Offsets that hold no register read 0x00.
- R6: In a cycle where `data_wr` is high, `data_out` still shows the value from before the write. The new value appears after the clock edge.
- R7: The post-divider selector register holds one 2-bit field per pixel clock, with clock n in bits [2n+1:2n]. `act_post` shows the field of the clock chosen by `clk_sel`.
- R8: The feedback divider of pixel clock n lives at offset 0x08+n. `act_fb` shows the divider of the clock chosen by `clk_sel`, and `fb_div_all[8n+7:8n]` carries the divider of clock n.
- R9: `mclk_post_code` equals bits [2:0] of the extended control register. `ext_ctl` carries all 8 bits of that register.
- R10: On a clock edge with `sel_wr` high, `clk_sel` takes `sel_in` and keeps it until the next `sel_wr` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_wr | input | 1 | Strobe that latches the address byte |
| addr_in | input | 8 | Address byte: offset in [7:2], write enable in [1] |
| data_wr | input | 1 | Data port write strobe |
| data_in | input | 8 | Data byte to write |
| data_out | output | 8 | Register at the latched offset |
| sel_wr | input | 1 | Strobe that loads the pixel clock select |
| sel_in | input | 2 | New pixel clock select |
| clk_sel | output | 2 | Active pixel clock select |
| gen_ctl | output | 8 | General control register |
| ref_div | output | 8 | Reference divider register |
| post_sel | output | 8 | Packed post-divider selector register |
| ext_ctl | output | 8 | Extended control register |
| fb_div_all | output | 32 | All feedback dividers, clock n in [8n+7:8n] |
| act_post | output | 2 | Post-divider field of the selected clock |
| act_fb | output | 8 | Feedback divider of the selected clock |
| mclk_post_code | output | 3 | Memory clock post-divider code |

## Verification
The bench builds the block with its default parameters: a 6-bit offset, 8-bit registers and four pixel clocks. With these values every field of the packed post-divider byte and all four feedback divider offsets can be reached, and so can the unmapped top of the offset space (0x3F). Because the byte is fully packed with four 2-bit fields, a field that is shifted or misplaced by one clock shows up on `act_post` as soon as the bench walks `clk_sel` through all four values. The 6-bit offset lets the bench reach both an unmapped offset next to the register block and one at the far end of the offset space.

// File: rtl/pllreg_pkg.sv
package pllreg_pkg;
  localparam int OFF_W  = 6;
  localparam int DATA_W = 8;
  localparam int FLD_W  = 2;

  // Register offsets (feedback dividers occupy FB_BASE .. FB_BASE+NUM_CLK-1)
  localparam logic [OFF_W-1:0] OFF_GEN  = 6'h01;
  localparam logic [OFF_W-1:0] OFF_REF  = 6'h03;
  localparam logic [OFF_W-1:0] OFF_POST = 6'h04;
  localparam logic [OFF_W-1:0] OFF_FB0  = 6'h08;
  localparam logic [OFF_W-1:0] OFF_EXT  = 6'h0C;

  // Pick the 2-bit post-divider field of clock idx from a packed byte
  function automatic logic [FLD_W-1:0] post_field(input logic [DATA_W-1:0] packed_r,
                                                  input int unsigned idx);
    logic [DATA_W-1:0] shifted;
    shifted = packed_r >> (FLD_W * idx);
    return shifted[FLD_W-1:0];
  endfunction

  // True when off addresses feedback divider slot of some clock
  function automatic logic is_fb_off(input logic [OFF_W-1:0] off, input int unsigned nclk);
    return (off >= OFF_FB0) && (int'(off - OFF_FB0) < nclk);
  endfunction
endpackage

// File: rtl/pllreg_addr.sv
module pllreg_addr #(
  parameter int OFF_W  = 6,
  parameter int WE_BIT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addr_wr,
  input  logic [OFF_W+1:0] addr_in,
  output logic [OFF_W-1:0] off_q,
  output logic             we_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= '0;
      we_q  <= 1'b0;
    end else if (addr_wr) begin
      off_q <= addr_in[OFF_W+1:2];
      we_q  <= addr_in[WE_BIT];
    end
  end
endmodule

// File: rtl/pllreg_bank.sv
module pllreg_bank
  import pllreg_pkg::*;
#(
  parameter int NUM_CLK = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_evt,
  input  logic [OFF_W-1:0]          wr_off,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [DATA_W-1:0]         gen_q,
  output logic [DATA_W-1:0]         ref_q,
  output logic [DATA_W-1:0]         post_q,
  output logic [DATA_W-1:0]         ext_q,
  output logic [NUM_CLK*DATA_W-1:0] fb_q
);
  function automatic logic hit(input logic [OFF_W-1:0] a, input logic [OFF_W-1:0] b);
    return a == b;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q  <= '0;
      ref_q  <= '0;
      post_q <= '0;
      ext_q  <= '0;
    end else if (wr_evt) begin
      if (hit(wr_off, OFF_GEN))  gen_q  <= wr_data;
      if (hit(wr_off, OFF_REF))  ref_q  <= wr_data;
      if (hit(wr_off, OFF_POST)) post_q <= wr_data;
      if (hit(wr_off, OFF_EXT))  ext_q  <= wr_data;
    end
  end

  for (genvar n = 0; n < NUM_CLK; n++) begin : g_fb
    localparam logic [OFF_W-1:0] MY_OFF = OFF_FB0 + OFF_W'(n);
    always_ff @(posedge clk) begin
      if (rst)
        fb_q[n*DATA_W +: DATA_W] <= '0;
      else if (wr_evt && hit(wr_off, MY_OFF))
        fb_q[n*DATA_W +: DATA_W] <= wr_data;
    end
  end
endmodule

// File: rtl/pllreg_rdmux.sv
module pllreg_rdmux
  import pllreg_pkg::*;
#(
  parameter int NUM_CLK = 4
) (
  input  logic [OFF_W-1:0]          off,
  input  logic [DATA_W-1:0]         gen_q,
  input  logic [DATA_W-1:0]         ref_q,
  input  logic [DATA_W-1:0]         post_q,
  input  logic [DATA_W-1:0]         ext_q,
  input  logic [NUM_CLK*DATA_W-1:0] fb_q,
  output logic [DATA_W-1:0]         rdata,
  output logic                      rd_hit
);
  logic [OFF_W-1:0] fb_idx;
  assign fb_idx = off - OFF_FB0;

  always_comb begin
    rdata  = '0;
    rd_hit = 1'b1;
    if (off == OFF_GEN)                rdata = gen_q;
    else if (off == OFF_REF)           rdata = ref_q;
    else if (off == OFF_POST)          rdata = post_q;
    else if (off == OFF_EXT)           rdata = ext_q;
    else if (is_fb_off(off, NUM_CLK))  rdata = fb_q[fb_idx*DATA_W +: DATA_W];
    else                               rd_hit = 1'b0;
  end
endmodule

// File: rtl/pllreg_port.sv
module pllreg_port
  import pllreg_pkg::*;
#(
  parameter int NUM_CLK = 4,
  localparam int SEL_W  = $clog2(NUM_CLK)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      addr_wr,
  input  logic [OFF_W+1:0]          addr_in,
  input  logic                      data_wr,
  input  logic [DATA_W-1:0]         data_in,
  output logic [DATA_W-1:0]         data_out,
  input  logic                      sel_wr,
  input  logic [SEL_W-1:0]          sel_in,
  output logic [SEL_W-1:0]          clk_sel,
  output logic [DATA_W-1:0]         gen_ctl,
  output logic [DATA_W-1:0]         ref_div,
  output logic [DATA_W-1:0]         post_sel,
  output logic [DATA_W-1:0]         ext_ctl,
  output logic [NUM_CLK*DATA_W-1:0] fb_div_all,
  output logic [FLD_W-1:0]          act_post,
  output logic [DATA_W-1:0]         act_fb,
  output logic [2:0]                mclk_post_code
);
  logic [OFF_W-1:0] off_q;
  logic             we_q;
  logic             wr_evt;
  logic             rd_hit;

  pllreg_addr #(.OFF_W(OFF_W), .WE_BIT(1)) u_addr (
    .clk(clk), .rst(rst), .addr_wr(addr_wr), .addr_in(addr_in),
    .off_q(off_q), .we_q(we_q)
  );

  // Write reaches the bank only with the latched enable flag
  assign wr_evt = data_wr & we_q;

  pllreg_bank #(.NUM_CLK(NUM_CLK)) u_bank (
    .clk(clk), .rst(rst), .wr_evt(wr_evt), .wr_off(off_q), .wr_data(data_in),
    .gen_q(gen_ctl), .ref_q(ref_div), .post_q(post_sel), .ext_q(ext_ctl),
    .fb_q(fb_div_all)
  );

  pllreg_rdmux #(.NUM_CLK(NUM_CLK)) u_rd (
    .off(off_q), .gen_q(gen_ctl), .ref_q(ref_div), .post_q(post_sel),
    .ext_q(ext_ctl), .fb_q(fb_div_all), .rdata(data_out), .rd_hit(rd_hit)
  );

  always_ff @(posedge clk) begin
    if (rst)         clk_sel <= '0;
    else if (sel_wr) clk_sel <= sel_in;
  end

  assign act_post       = post_field(post_sel, int'(clk_sel));
  assign act_fb         = fb_div_all[int'(clk_sel)*DATA_W +: DATA_W];
  assign mclk_post_code = ext_ctl[2:0];
endmodule

// File: rtl/pllreg_port_chk.sv
module pllreg_port_chk
  import pllreg_pkg::*;
#(
  parameter int NUM_CLK = 4,
  localparam int SEL_W  = $clog2(NUM_CLK)
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      addr_wr,
  input logic [OFF_W+1:0]          addr_in,
  input logic                      data_wr,
  input logic [DATA_W-1:0]         data_in,
  input logic [DATA_W-1:0]         data_out,
  input logic                      sel_wr,
  input logic [SEL_W-1:0]          sel_in,
  input logic [SEL_W-1:0]          clk_sel,
  input logic [DATA_W-1:0]         gen_ctl,
  input logic [DATA_W-1:0]         ref_div,
  input logic [DATA_W-1:0]         post_sel,
  input logic [DATA_W-1:0]         ext_ctl,
  input logic [NUM_CLK*DATA_W-1:0] fb_div_all,
  input logic [FLD_W-1:0]          act_post,
  input logic [OFF_W-1:0]          off_q,
  input logic                      we_q,
  input logic                      wr_evt,
  input logic                      rd_hit
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (gen_ctl == '0 && ref_div == '0 && post_sel == '0 && ext_ctl == '0 &&
             fb_div_all == '0 && clk_sel == '0 && !we_q));

  // R2
  addr_latch_chk: assert property (@(posedge clk) disable iff (rst)
    addr_wr |=> (off_q == $past(addr_in[OFF_W+1:2]) && we_q == $past(addr_in[1])));

  // R3
  ref_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && off_q == OFF_REF) |=> ref_div == $past(data_in));

  // R4
  wr_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !we_q) |=> ($stable(gen_ctl) && $stable(ref_div) && $stable(post_sel) &&
                            $stable(ext_ctl) && $stable(fb_div_all)));

  // R5
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |-> data_out == '0);

  // R7
  post_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(post_sel) && $stable(clk_sel)) |-> $stable(act_post));

  // R10
  sel_load_chk: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> clk_sel == $past(sel_in));
endmodule

bind pllreg_port pllreg_port_chk #(.NUM_CLK(NUM_CLK)) u_chk (
  .clk(clk), .rst(rst), .addr_wr(addr_wr), .addr_in(addr_in), .data_wr(data_wr),
  .data_in(data_in), .data_out(data_out), .sel_wr(sel_wr), .sel_in(sel_in),
  .clk_sel(clk_sel), .gen_ctl(gen_ctl), .ref_div(ref_div), .post_sel(post_sel),
  .ext_ctl(ext_ctl), .fb_div_all(fb_div_all), .act_post(act_post),
  .off_q(off_q), .we_q(we_q), .wr_evt(wr_evt), .rd_hit(rd_hit)
);

// File: tb/tb_pllreg_port.sv
`timescale 1ns/1ps
module tb_pllreg_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_wr = 1'b0;
  logic [7:0]  addr_in = '0;
  logic        data_wr = 1'b0;
  logic [7:0]  data_in = '0;
  logic [7:0]  data_out;
  logic        sel_wr = 1'b0;
  logic [1:0]  sel_in = '0;
  logic [1:0]  clk_sel;
  logic [7:0]  gen_ctl, ref_div, post_sel, ext_ctl;
  logic [31:0] fb_div_all;
  logic [1:0]  act_post;
  logic [7:0]  act_fb;
  logic [2:0]  mclk_post_code;

  int errors = 0;
  int checks = 0;
  logic rd_pulse = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } rd_item_t;
  rd_item_t exp_q[$];
  logic [7:0] model [64];

  always #2 clk = ~clk;

  pllreg_port dut (
    .clk(clk), .rst(rst), .addr_wr(addr_wr), .addr_in(addr_in), .data_wr(data_wr),
    .data_in(data_in), .data_out(data_out), .sel_wr(sel_wr), .sel_in(sel_in),
    .clk_sel(clk_sel), .gen_ctl(gen_ctl), .ref_div(ref_div), .post_sel(post_sel),
    .ext_ctl(ext_ctl), .fb_div_all(fb_div_all), .act_post(act_post), .act_fb(act_fb),
    .mclk_post_code(mclk_post_code)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard away from the clock edges
  initial forever begin
    @(negedge clk); #1;
    if (rd_pulse) begin
      if (exp_q.size() == 0) chk(32'hdead, 32'h0, "scoreboard empty");
      else begin
        rd_item_t it;
        it = exp_q.pop_front();
        chk(32'(data_out), 32'(it.exp), it.tag);
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic set_addr(input logic [5:0] off, input logic we, input logic b0);
    addr_wr = 1'b1; addr_in = {off, we, b0}; tick(); addr_wr = 1'b0;
  endtask

  task automatic reg_write(input logic [5:0] off, input logic [7:0] val);
    set_addr(off, 1'b1, 1'b0);
    data_wr = 1'b1; data_in = val; tick(); data_wr = 1'b0;
    set_addr(off, 1'b0, 1'b0);
    if (off == 6'h01 || off == 6'h03 || off == 6'h04 || off == 6'h0C ||
        (off >= 6'h08 && off <= 6'h0B)) model[off] = val;
  endtask

  task automatic reg_read(input logic [5:0] off, input string tag);
    set_addr(off, 1'b0, 1'b0);
    exp_q.push_back('{model[off], tag});
    rd_pulse = 1'b1; tick(); rd_pulse = 1'b0;
  endtask

  task automatic load_sel(input logic [1:0] v);
    sel_wr = 1'b1; sel_in = v; tick(); sel_wr = 1'b0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    foreach (model[i]) model[i] = 8'h00;
    tick(); tick(); tick();
    rst = 1'b0;
    tick(); #1;
    // R1 reset state
    chk(32'(clk_sel), 0, "R1 clk_sel after reset");
    chk(32'(act_fb), 0, "R1 act_fb after reset");
    chk(fb_div_all, 0, "R1 fb dividers after reset");
    tick();
    reg_read(6'h03, "R1 ref divider reads zero");

    // R3 / R5 basic writes
    reg_write(6'h03, 8'h5A);
    reg_read(6'h03, "R3 R5 ref divider readback");
    reg_write(6'h01, 8'hC3);
    reg_read(6'h01, "R3 R5 general control readback");
    #1 chk(32'(gen_ctl), 32'hC3, "R3 gen_ctl output");
    tick();

    // R2: bit0 ignored, write enable in bit1
    set_addr(6'h0C, 1'b1, 1'b1);
    data_wr = 1'b1; data_in = 8'hB7; tick(); data_wr = 1'b0;
    model[6'h0C] = 8'hB7;
    set_addr(6'h0C, 1'b0, 1'b1);
    reg_read(6'h0C, "R2 R3 extended control with bit0 set");
    #1;
    // R9
    chk(32'(mclk_post_code), 32'h7, "R9 memory clock post code");
    chk(32'(ext_ctl), 32'hB7, "R9 extended control output");
    tick();

    // R4: write with enable clear ignored
    set_addr(6'h03, 1'b0, 1'b0);
    data_wr = 1'b1; data_in = 8'h11; tick(); data_wr = 1'b0;
    #1 chk(32'(ref_div), 32'h5A, "R4 ref_div unchanged");
    tick();
    reg_read(6'h03, "R4 ignored write readback");

    // R5 unmapped offsets
    reg_read(6'h02, "R5 unmapped 0x02");
    reg_read(6'h3F, "R5 unmapped 0x3F");
    reg_read(6'h0D, "R5 unmapped 0x0D");

    // R6 same-cycle write and read
    set_addr(6'h03, 1'b1, 1'b0);
    data_wr = 1'b1; data_in = 8'h9C;
    exp_q.push_back('{8'h5A, "R6 pre-write value during write"});
    rd_pulse = 1'b1; tick(); rd_pulse = 1'b0; data_wr = 1'b0;
    model[6'h03] = 8'h9C;
    exp_q.push_back('{8'h9C, "R6 new value after edge"});
    rd_pulse = 1'b1; tick(); rd_pulse = 1'b0;
    set_addr(6'h03, 1'b0, 1'b0);

    // R7 packed post-divider fields, R8 feedback dividers
    reg_write(6'h04, 8'hE4);
    reg_write(6'h08, 8'h80);
    reg_write(6'h09, 8'h91);
    reg_write(6'h0A, 8'hA2);
    reg_write(6'h0B, 8'hFF);
    for (int s = 0; s < 4; s++) begin
      load_sel(2'(s));
      #1;
      chk(32'(clk_sel), s, "R10 clock select load");
      chk(32'(act_post), 32'((model[6'h04] >> (2*s)) & 8'h3), "R7 active post field");
      chk(32'(act_fb), 32'(model[6'h08 + s]), "R8 active feedback divider");
      chk(32'(fb_div_all[8*s +: 8]), 32'(model[6'h08 + s]), "R8 flat divider slot");
      tick();
    end
    // R7 different pattern
    reg_write(6'h04, 8'h1B);
    load_sel(2'd1);
    #1 chk(32'(act_post), 32'h2, "R7 field 1 of 0x1B");
    tick();
    reg_read(6'h0A, "R8 feedback divider 2 readback");

    // R10 select held without strobe
    sel_in = 2'd3; tick(); tick();
    #1 chk(32'(clk_sel), 32'h1, "R10 select held");
    tick();

    // R1 reset mid-run
    rst = 1'b1; tick(); rst = 1'b0;
    foreach (model[i]) model[i] = 8'h00;
    #1;
    chk(32'(post_sel), 0, "R1 post register after reset");
    chk(32'(clk_sel), 0, "R1 select after reset");
    tick();
    reg_read(6'h0B, "R1 feedback divider 3 after reset");

    tick(); tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule